// File: doc/BRIEF.md
# Super I/O configuration register file

This block holds the plug-and-play configuration space of a legacy multi-function I/O chip. The host reaches it through a two-byte I/O window. The lower port is an index register and the upper port is a data register. Configuration is closed after reset. Two back-to-back writes of 0x87 to the index port open it. A write of 0xAA to the index port closes it again.

With the space open, the host chooses a logical device by writing its number to index 0x07. It then reaches that device's banked bytes at index 0x30 and above: an activate flag, three I/O base addresses, two IRQ numbers, a DMA channel and two option bytes. A few chip-wide registers are shared by all devices: the identity bytes, the per-function power-down bits and a whole-chip power-down bit. The decoded settings of every logical device are driven out continuously. The UARTs, floppy controller, parallel port and keyboard controller in the rest of the chip use them.

Logical device 0 is the floppy controller, logical device 1 the parallel port, 2 and 3 the two UARTs, and 5 the keyboard controller. Logical device 4 is present but has no defaults.

Top module: `sio_cfg_regs`

## Requirements
- R1: `io_addr`=0 selects the index port and `io_addr`=1 the data port. While configuration is open, a write to the index port that is not 0xAA stores the index, and a read of the index port returns it. A read of the data port returns the register selected by the index. Reads have no side effects.
- R2: Configuration opens only when two consecutive index-port writes both carry 0x87. Any other value written to the index port while the space is closed restarts the key sequence.
- R3: While configuration is open, an index-port write of 0xAA closes it and leaves the stored index unchanged.
- R4: While configuration is closed, data-port writes change nothing, and reads of either port return 0xFF.
- R5: Index 0x07 holds the logical device number. Registers at 0x30 and above are banked by it, and each device keeps its own copy.
- R6: Index 0x20 reads 0x97 and index 0x21 reads the revision parameter (default 0x73). Writes to both are ignored.
- R7: The bits of index 0x22 map to `dev_pd` as follows. Bit 0 drives `dev_pd[0]` (floppy), bit 3 drives `dev_pd[1]` (parallel port), bit 4 drives `dev_pd[2]` (UART A) and bit 5 drives `dev_pd[3]` (UART B). Bits 1, 2, 6 and 7 read as 0. Bit 0 of index 0x23 drives `chip_pd`, and its other bits read as 0.
- R8: Bit 0 of index 0x30 is the device's activate flag and drives `dev_active[ldn]`. Its other bits read as 0.
- R9: I/O base n (n=0,1,2) is stored with the high byte at index 0x60+2n and the low byte at index 0x61+2n. It appears on `dev_io<n>[16*ldn +: 16]`. For the floppy device, the low three bits written to index 0x61 are forced to 0.
- R10: Index 0x70 holds the first IRQ, 0x72 the second IRQ and 0x74 the DMA channel, each as a full byte on `dev_irq0`, `dev_irq1` and `dev_dma` (8 bits per device). Indices 0xF0 and 0xF1 are option bytes that read back as written.
- R11: Bit 1 of the parallel device's option byte at 0xF0 drives `par_ext_en`. `par_ext_base` is that device's base 0 plus 0x400.
- R12: After reset the space is closed, the index is 0, no device is active, and all power-down bits are 0. Base 0 defaults are 0x03F0, 0x0378, 0x03F8, 0x02F8, 0x0000 and 0x0060 for devices 0 to 5. Keyboard base 1 defaults to 0x0064. First-IRQ defaults are 6, 7, 4, 3, 0 and 1. Keyboard second IRQ defaults to 12. DMA defaults to 2 for the floppy and 4 (none) for all other devices.
- R13: While a device number of `NUM_LDN` or above is selected, banked reads return 0x00 and banked writes are dropped. Indices with no register read 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_wr | input | 1 | Write strobe for one cycle |
| io_addr | input | 1 | 0 selects the index port, 1 the data port |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data for the selected port |
| cfg_open | output | 1 | Configuration space is open |
| dev_active | output | NUM_LDN | Activate flag per device |
| dev_io0 | output | 16*NUM_LDN | I/O base 0 per device |
| dev_io1 | output | 16*NUM_LDN | I/O base 1 per device |
| dev_io2 | output | 16*NUM_LDN | I/O base 2 per device |
| dev_irq0 | output | 8*NUM_LDN | First IRQ per device |
| dev_irq1 | output | 8*NUM_LDN | Second IRQ per device |
| dev_dma | output | 8*NUM_LDN | DMA channel per device |
| dev_pd | output | 4 | Power-down for floppy, parallel, UART A, UART B |
| chip_pd | output | 1 | Whole-chip power-down |
| par_ext_en | output | 1 | Parallel port extended mode |
| par_ext_base | output | 16 | Second range of the parallel port |

## Verification
The hardest situation to reach is a false start of the key. The space must stay closed after an 0x87, a different value and then a single 0x87. The bench drives exactly that pattern before it completes the key. The second hard situation is a re-lock. The bench leaves a banked index selected, closes the space and pokes the data port. It then reopens the space and reads the index port and the data port back, to show that neither the stored index nor the bank moved. Out-of-range device numbers are reached by writing 7 to index 0x07 and then confirming through a valid device that the dropped write touched nothing.

// File: rtl/sio_cfg_regs.sv
module sio_cfg_regs #(
  parameter int NUM_LDN = 6,
  parameter int FDC_LDN = 0,
  parameter int PAR_LDN = 1,
  parameter logic [7:0] REV = 8'h73,
  parameter logic [NUM_LDN*16-1:0] DEF_IO0 = {16'h0060, 16'h0000, 16'h02F8, 16'h03F8, 16'h0378, 16'h03F0},
  parameter logic [NUM_LDN*16-1:0] DEF_IO1 = {16'h0064, 16'h0000, 16'h0000, 16'h0000, 16'h0000, 16'h0000},
  parameter logic [NUM_LDN*16-1:0] DEF_IO2 = '0,
  parameter logic [NUM_LDN*8-1:0]  DEF_IRQ0 = {8'd1, 8'd0, 8'd3, 8'd4, 8'd7, 8'd6},
  parameter logic [NUM_LDN*8-1:0]  DEF_IRQ1 = {8'd12, 8'd0, 8'd0, 8'd0, 8'd0, 8'd0},
  parameter logic [NUM_LDN*8-1:0]  DEF_DMA  = {8'd4, 8'd4, 8'd4, 8'd4, 8'd4, 8'd2}
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   io_wr,
  input  logic                   io_addr,
  input  logic [7:0]             io_wdata,
  output logic [7:0]             io_rdata,
  output logic                   cfg_open,
  output logic [NUM_LDN-1:0]     dev_active,
  output logic [NUM_LDN*16-1:0]  dev_io0,
  output logic [NUM_LDN*16-1:0]  dev_io1,
  output logic [NUM_LDN*16-1:0]  dev_io2,
  output logic [NUM_LDN*8-1:0]   dev_irq0,
  output logic [NUM_LDN*8-1:0]   dev_irq1,
  output logic [NUM_LDN*8-1:0]   dev_dma,
  output logic [3:0]             dev_pd,
  output logic                   chip_pd,
  output logic                   par_ext_en,
  output logic [15:0]            par_ext_base
);
  localparam int NSLOT = 12;
  localparam int LW = (NUM_LDN > 1) ? $clog2(NUM_LDN) : 1;
  localparam logic [7:0] KEY_OPEN = 8'h87;
  localparam logic [7:0] KEY_EXIT = 8'hAA;
  localparam logic [7:0] CHIP_ID  = 8'h97;

  typedef enum logic [1:0] {S_LOCK, S_KEY, S_OPEN} st_t;

  st_t         st;
  logic [7:0]  idx, ldn, pd_reg, dval, wv;
  logic        ipd, sl_ok, ldn_ok;
  logic [3:0]  sl;
  logic [LW-1:0] ldn_sel;
  logic [7:0]  bnk [NUM_LDN][NSLOT];

  function automatic logic [7:0] dflt(int d, int s);
    case (s)
      1: return DEF_IO0[d*16+8 +: 8];
      2: return DEF_IO0[d*16 +: 8];
      3: return DEF_IO1[d*16+8 +: 8];
      4: return DEF_IO1[d*16 +: 8];
      5: return DEF_IO2[d*16+8 +: 8];
      6: return DEF_IO2[d*16 +: 8];
      7: return DEF_IRQ0[d*8 +: 8];
      8: return DEF_IRQ1[d*8 +: 8];
      9: return DEF_DMA[d*8 +: 8];
      default: return 8'h00;
    endcase
  endfunction

  assign cfg_open = (st == S_OPEN);
  assign ldn_sel  = ldn[LW-1:0];
  assign ldn_ok   = (ldn < 8'(NUM_LDN));

  always_comb begin
    sl_ok = 1'b1;
    sl    = 4'd0;
    case (idx)
      8'h30: sl = 4'd0;
      8'h60: sl = 4'd1;
      8'h61: sl = 4'd2;
      8'h62: sl = 4'd3;
      8'h63: sl = 4'd4;
      8'h64: sl = 4'd5;
      8'h65: sl = 4'd6;
      8'h70: sl = 4'd7;
      8'h72: sl = 4'd8;
      8'h74: sl = 4'd9;
      8'hF0: sl = 4'd10;
      8'hF1: sl = 4'd11;
      default: sl_ok = 1'b0;
    endcase
  end

  always_comb begin
    wv = io_wdata;
    if (sl == 4'd0)
      wv = {7'b0, io_wdata[0]};
    else if (sl == 4'd2 && ldn_sel == LW'(FDC_LDN))
      wv = io_wdata & 8'hF8;
  end

  always_comb begin
    dval = 8'h00;
    case (idx)
      8'h07: dval = ldn;
      8'h20: dval = CHIP_ID;
      8'h21: dval = REV;
      8'h22: dval = pd_reg;
      8'h23: dval = {7'b0, ipd};
      default: if (sl_ok && ldn_ok) dval = bnk[ldn_sel][sl];
    endcase
  end

  assign io_rdata = !cfg_open ? 8'hFF : (io_addr ? dval : idx);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_LOCK;
      idx    <= 8'h00;
      ldn    <= 8'h00;
      pd_reg <= 8'h00;
      ipd    <= 1'b0;
      for (int d = 0; d < NUM_LDN; d++)
        for (int s = 0; s < NSLOT; s++)
          bnk[d][s] <= dflt(d, s);
    end else if (io_wr) begin
      if (!io_addr) begin
        case (st)
          S_LOCK: st <= (io_wdata == KEY_OPEN) ? S_KEY : S_LOCK;
          S_KEY:  st <= (io_wdata == KEY_OPEN) ? S_OPEN : S_LOCK;
          default: begin
            if (io_wdata == KEY_EXIT) st <= S_LOCK;
            else idx <= io_wdata;
          end
        endcase
      end else if (st == S_OPEN) begin
        case (idx)
          8'h07: ldn <= io_wdata;
          8'h22: pd_reg <= io_wdata & 8'h39;
          8'h23: ipd <= io_wdata[0];
          default: if (sl_ok && ldn_ok) bnk[ldn_sel][sl] <= wv;
        endcase
      end
    end
  end

  for (genvar g = 0; g < NUM_LDN; g++) begin : g_out
    assign dev_active[g]         = bnk[g][0][0];
    assign dev_io0[g*16 +: 16]   = {bnk[g][1], bnk[g][2]};
    assign dev_io1[g*16 +: 16]   = {bnk[g][3], bnk[g][4]};
    assign dev_io2[g*16 +: 16]   = {bnk[g][5], bnk[g][6]};
    assign dev_irq0[g*8 +: 8]    = bnk[g][7];
    assign dev_irq1[g*8 +: 8]    = bnk[g][8];
    assign dev_dma[g*8 +: 8]     = bnk[g][9];
  end

  assign dev_pd       = {pd_reg[5], pd_reg[4], pd_reg[3], pd_reg[0]};
  assign chip_pd      = ipd;
  assign par_ext_en   = bnk[PAR_LDN][10][1];
  assign par_ext_base = {bnk[PAR_LDN][1], bnk[PAR_LDN][2]} + 16'h0400;

  AST_KEY_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
    (io_wr && !io_addr && io_wdata == KEY_OPEN && st == S_KEY) |=> cfg_open); // R2
  AST_KEY_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (io_wr && !io_addr && io_wdata != KEY_OPEN && !cfg_open) |=> !cfg_open); // R2
  AST_EXIT_KEEPS_IDX: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_open && io_wr && !io_addr && io_wdata == KEY_EXIT) |=> (!cfg_open && $stable(idx))); // R3
  AST_LOCKED_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_open |=> ($stable(ldn) && $stable(pd_reg) && $stable(ipd) && $stable(dev_irq0))); // R4
  AST_FDC_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
    dev_io0[FDC_LDN*16 +: 3] == 3'b000); // R9
endmodule

// File: tb/sim_sio_cfg_regs.sv
module sim_sio_cfg_regs;
  localparam int N = 6;
  logic clk = 1'b0, rst_n = 1'b0, io_wr = 1'b0, io_addr = 1'b0;
  logic [7:0] io_wdata = 8'h00, io_rdata;
  logic cfg_open, chip_pd, par_ext_en;
  logic [N-1:0] dev_active;
  logic [N*16-1:0] dev_io0, dev_io1, dev_io2;
  logic [N*8-1:0] dev_irq0, dev_irq1, dev_dma;
  logic [3:0] dev_pd;
  logic [15:0] par_ext_base;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  sio_cfg_regs u0 (.clk(clk), .rst_n(rst_n), .io_wr(io_wr), .io_addr(io_addr),
    .io_wdata(io_wdata), .io_rdata(io_rdata), .cfg_open(cfg_open),
    .dev_active(dev_active), .dev_io0(dev_io0), .dev_io1(dev_io1), .dev_io2(dev_io2),
    .dev_irq0(dev_irq0), .dev_irq1(dev_irq1), .dev_dma(dev_dma), .dev_pd(dev_pd),
    .chip_pd(chip_pd), .par_ext_en(par_ext_en), .par_ext_base(par_ext_base));

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic wr(logic a, logic [7:0] d);
    @(negedge clk); io_addr = a; io_wdata = d; io_wr = 1'b1;
    @(negedge clk); io_wr = 1'b0;
  endtask

  task automatic rd(logic a, output logic [7:0] d);
    @(negedge clk); io_addr = a; io_wr = 1'b0; #1; d = io_rdata;
  endtask

  task automatic cwr(logic [7:0] i, logic [7:0] d);
    wr(1'b0, i); wr(1'b1, d);
  endtask

  task automatic crd(logic [7:0] i, output logic [7:0] d);
    wr(1'b0, i); rd(1'b1, d);
  endtask

  task automatic unlock();
    wr(1'b0, 8'h87); wr(1'b0, 8'h87);
  endtask

  task automatic t_reset();
    logic [7:0] v;
    chk("R12", "open", cfg_open, 0);
    chk("R12", "active", dev_active, 0);
    chk("R12", "fdc base", dev_io0[0 +: 16], 16'h03F0);
    chk("R12", "par base", dev_io0[16 +: 16], 16'h0378);
    chk("R12", "uarta base", dev_io0[32 +: 16], 16'h03F8);
    chk("R12", "kbc base1", dev_io1[80 +: 16], 16'h0064);
    chk("R12", "par irq", dev_irq0[8 +: 8], 7);
    chk("R12", "kbc irq1", dev_irq1[40 +: 8], 12);
    chk("R12", "fdc dma", dev_dma[0 +: 8], 2);
    chk("R12", "pd", {dev_pd, chip_pd, par_ext_en}, 0);
    rd(1'b1, v); chk("R4", "locked data read", v, 8'hFF);
  endtask

  task automatic t_unlock();
    logic [7:0] v;
    wr(1'b0, 8'h87); wr(1'b0, 8'h12); wr(1'b0, 8'h87);
    chk("R2", "broken key stays closed", cfg_open, 0);
    rd(1'b0, v); chk("R4", "locked index read", v, 8'hFF);
    wr(1'b0, 8'h87);
    chk("R2", "key opens", cfg_open, 1);
    rd(1'b0, v); chk("R12", "index after reset", v, 8'h00);
  endtask

  task automatic t_window();
    logic [7:0] v;
    wr(1'b0, 8'h07); rd(1'b0, v); chk("R1", "index readback", v, 8'h07);
    rd(1'b1, v); chk("R1", "ldn read", v, 8'h00);
  endtask

  task automatic t_ids();
    logic [7:0] v;
    crd(8'h20, v); chk("R6", "id", v, 8'h97);
    crd(8'h21, v); chk("R6", "rev", v, 8'h73);
    cwr(8'h20, 8'h00); crd(8'h20, v); chk("R6", "id write ignored", v, 8'h97);
  endtask

  task automatic t_bank();
    logic [7:0] v;
    cwr(8'h07, 8'h02);
    cwr(8'h70, 8'h05);
    cwr(8'h30, 8'hFF);
    crd(8'h30, v); chk("R8", "act readback", v, 8'h01);
    chk("R8", "dev_active", dev_active, 6'b000100);
    cwr(8'h07, 8'h03);
    crd(8'h70, v); chk("R5", "uartb irq default", v, 8'h03);
    cwr(8'h70, 8'h09);
    chk("R5", "ldn2 irq", dev_irq0[16 +: 8], 8'h05);
    chk("R10", "ldn3 irq", dev_irq0[24 +: 8], 8'h09);
    cwr(8'h72, 8'h0B); chk("R10", "irq1", dev_irq1[24 +: 8], 8'h0B);
    cwr(8'h74, 8'h01); chk("R10", "dma", dev_dma[24 +: 8], 8'h01);
    cwr(8'hF1, 8'hA5); crd(8'hF1, v); chk("R10", "opt1", v, 8'hA5);
  endtask

  task automatic t_io();
    logic [7:0] v;
    cwr(8'h07, 8'h00);
    cwr(8'h60, 8'h02); cwr(8'h61, 8'h7F);
    chk("R9", "fdc base aligned", dev_io0[0 +: 16], 16'h0278);
    crd(8'h61, v); chk("R9", "fdc low byte", v, 8'h78);
    cwr(8'h07, 8'h03);
    cwr(8'h62, 8'h12); cwr(8'h63, 8'h3F);
    chk("R9", "uartb base1 unmasked", dev_io1[48 +: 16], 16'h123F);
    cwr(8'h64, 8'hAB); cwr(8'h65, 8'hCD);
    chk("R9", "uartb base2", dev_io2[48 +: 16], 16'hABCD);
  endtask

  task automatic t_ext();
    cwr(8'h07, 8'h01);
    cwr(8'h60, 8'h02); cwr(8'h61, 8'h78);
    cwr(8'hF0, 8'h02);
    chk("R11", "ext en", par_ext_en, 1);
    chk("R11", "ext base", par_ext_base, 16'h0678);
    cwr(8'hF0, 8'h00);
    chk("R11", "ext off", par_ext_en, 0);
  endtask

  task automatic t_pd();
    logic [7:0] v;
    cwr(8'h22, 8'hFF); crd(8'h22, v); chk("R7", "pd readback", v, 8'h39);
    chk("R7", "pd all", dev_pd, 4'hF);
    cwr(8'h22, 8'h10); chk("R7", "uarta only", dev_pd, 4'b0100);
    cwr(8'h23, 8'hFF); crd(8'h23, v); chk("R7", "chip pd read", v, 8'h01);
    chk("R7", "chip pd", chip_pd, 1);
  endtask

  task automatic t_unimpl();
    logic [7:0] v;
    cwr(8'h07, 8'h07);
    cwr(8'h70, 8'h55); crd(8'h70, v); chk("R13", "oob ldn read", v, 8'h00);
    crd(8'h50, v); chk("R13", "hole read", v, 8'h00);
    chk("R13", "oob write dropped", dev_irq0, {8'd1, 8'd0, 8'd9, 8'd5, 8'd7, 8'd6});
  endtask

  task automatic t_lock();
    logic [7:0] v;
    cwr(8'h07, 8'h02);
    wr(1'b0, 8'h70);
    wr(1'b0, 8'hAA);
    chk("R3", "exit closes", cfg_open, 0);
    wr(1'b1, 8'h33);
    rd(1'b1, v); chk("R4", "locked data", v, 8'hFF);
    chk("R4", "locked write ignored", dev_irq0[16 +: 8], 8'h05);
    unlock();
    rd(1'b0, v); chk("R3", "index kept", v, 8'h70);
    rd(1'b1, v); chk("R4", "bank unchanged", v, 8'h05);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_unlock();
    t_window();
    t_ids();
    t_bank();
    t_io();
    t_ext();
    t_pd();
    t_unimpl();
    t_lock();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule